// File: doc/BRIEF.md
# Two-Peripheral APB Register Subsystem

This block sits behind a single APB3 completer port and splits it between two small peripherals at fixed addresses. A decoder compares the upper address bits against each peripheral's 16-byte window and raises exactly one internal select. The first peripheral keeps two 32-bit writable registers. Bit 0 of the first register drives an LED output. The second peripheral reads back the level of two switch inputs.

Each peripheral produces its own read data and its own ready signal. A response multiplexer returns only the selected peripheral's pair to the bus. A transfer that hits no window completes at once with zero data. Inside a peripheral, a register is chosen from the low 8 address bits only. The error response is held at 0, and neither peripheral ever inserts wait states.

Top module: `apbs_periph_sys`

## Requirements
- R1: While `presetn` is sampled low at a rising `pclk` edge, both registers clear to 0 and `led` goes to 0 on that edge.
- R2: A transfer to address 0x00001000 with `psel`, `penable` and `pwrite` all high loads `pwdata` into register A at that clock edge; a later read of 0x00001000 returns it.
- R3: A write transfer to 0x00001004 loads register B; a later read of 0x00001004 returns it, and register A is left unchanged.
- R4: `led` always equals bit 0 of register A.
- R5: No register changes on a cycle where `psel` is low, `penable` is low (setup phase) or `pwrite` is low.
- R6: Inside the first window, offsets 0x08 and 0x0C read as 0 and ignore writes; writes to the second window change no state.
- R7: A read of 0x00001010 returns `sw_a` in bit 0, and a read of 0x00001014 returns `sw_b` in bit 0; all other bits are 0. Other offsets in that window read 0.
- R8: An address outside 0x00001000 to 0x0000101F selects no peripheral: `prdata` is 0, `pready` is 1, and a write changes nothing, even when the low 8 address bits match a register offset.
- R9: `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Transfer targets this subsystem |
| penable | input | 1 | High in the access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 32 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data from the selected peripheral |
| pready | output | 1 | Ready from the selected peripheral, or 1 if none is selected |
| pslverr | output | 1 | Error response, always 0 |
| led | output | 1 | Bit 0 of register A |
| sw_a | input | 1 | First switch level |
| sw_b | input | 1 | Second switch level |

## Verification
Writes use distinct data words for A and B. This exposes a swapped or shared write enable, and alternating LSBs show whether the LED follows register A. Half transfers test the write qualification: one stops after the setup phase, and one raises penable and pwrite without psel. Writes to 0x00002000 and 0x00001100 carry a low byte equal to register A's offset, so they catch a decoder that looks only at the low bits. Switch reads are repeated with both switch combinations, which shows whether the read mux swaps the peripherals or the two words.

// File: rtl/apbs_pkg.sv
// Package apbs_pkg: shared address map and sizes for the two-peripheral
// APB subsystem. Assumes 16-byte peripheral windows on a 32-bit bus.
package apbs_pkg;
    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned OFS_W     = 8;
    localparam int unsigned SPAN_LOG2 = 4;
    localparam int unsigned NUM_SLV   = 2;
    localparam logic [ADDR_W-1:0] REGS_BASE = 32'h0000_1000;
    localparam logic [ADDR_W-1:0] SWCH_BASE = 32'h0000_1010;
    // slot of each peripheral in the select and response vectors
    typedef enum int unsigned { SLOT_REGS = 0, SLOT_SWCH = 1 } slot_e;
endpackage

// File: rtl/apbs_decode.sv
// Module apbs_decode: turns the bus select and the upper address bits into
// one select per peripheral. Assumes windows are aligned to 2**SPAN_LOG2
// and do not overlap, so at most one select is high.
module apbs_decode #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned SPAN_LOG2 = 4,
    parameter int unsigned NUM_SLV   = 2,
    parameter logic [NUM_SLV*ADDR_W-1:0] BASES = '0
) (
    input  logic                        psel,
    input  logic [ADDR_W-1:SPAN_LOG2]   paddr_hi,
    output logic [NUM_SLV-1:0]          slv_sel
);
    localparam int unsigned HI_W = ADDR_W - SPAN_LOG2;

    // one window comparator per peripheral
    for (genvar i = 0; i < NUM_SLV; i++) begin : g_win
        assign slv_sel[i] = psel &&
            (paddr_hi == BASES[i*ADDR_W+SPAN_LOG2 +: HI_W]);
    end
endmodule

// File: rtl/apbs_regdev.sv
// Module apbs_regdev: peripheral with two writable words. Writes land on the
// access-phase edge; reads are combinational and zero when not selected.
// Assumes the peripheral never stalls.
module apbs_regdev #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned OFS_W  = 8,
    parameter logic [OFS_W-1:0] OFS_A = 8'h00,
    parameter logic [OFS_W-1:0] OFS_B = 8'h04
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              sel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ready,
    output logic              led
);
    logic [DATA_W-1:0] word_a, word_b;
    logic              wr_go;

    assign wr_go = sel && penable && pwrite;

    // hold the two words, cleared by reset
    always_ff @(posedge pclk) begin
        if (!presetn) begin
            word_a <= '0;
            word_b <= '0;
        end else if (wr_go) begin
            if (ofs == OFS_A) word_a <= pwdata;
            if (ofs == OFS_B) word_b <= pwdata;
        end
    end

    // select the word addressed by the offset
    always_comb begin
        rdata = '0;
        if (sel) begin
            if (ofs == OFS_A)      rdata = word_a;
            else if (ofs == OFS_B) rdata = word_b;
        end
    end

    assign ready = 1'b1;
    assign led   = word_a[0];
endmodule

// File: rtl/apbs_swdev.sv
// Module apbs_swdev: read-only peripheral that returns one switch level per
// word in bit 0. Writes are ignored. Assumes switches are already synchronous.
module apbs_swdev #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned OFS_W  = 8,
    parameter logic [OFS_W-1:0] OFS_SA = 8'h10,
    parameter logic [OFS_W-1:0] OFS_SB = 8'h14
) (
    input  logic              sel,
    input  logic [OFS_W-1:0]  ofs,
    input  logic              sw_a,
    input  logic              sw_b,
    output logic [DATA_W-1:0] rdata,
    output logic              ready
);
    // place the addressed switch level in bit 0
    always_comb begin
        rdata = '0;
        if (sel) begin
            if (ofs == OFS_SA)      rdata[0] = sw_a;
            else if (ofs == OFS_SB) rdata[0] = sw_b;
        end
    end

    assign ready = 1'b1;
endmodule

// File: rtl/apbs_resp_mux.sv
// Module apbs_resp_mux: returns the selected peripheral's data and ready.
// With no select, data is 0 and ready is 1. Assumes selects are one-hot or zero.
module apbs_resp_mux #(
    parameter int unsigned NUM_SLV = 2,
    parameter int unsigned DATA_W  = 32
) (
    input  logic [NUM_SLV-1:0]        slv_sel,
    input  logic [NUM_SLV*DATA_W-1:0] slv_rdata,
    input  logic [NUM_SLV-1:0]        slv_ready,
    output logic [DATA_W-1:0]         prdata,
    output logic                      pready
);
    // AND-OR mux over the peripheral responses
    always_comb begin
        prdata = '0;
        pready = 1'b1;
        for (int i = 0; i < NUM_SLV; i++) begin
            if (slv_sel[i]) begin
                prdata = prdata | slv_rdata[i*DATA_W +: DATA_W];
                pready = slv_ready[i];
            end
        end
    end
endmodule

// File: rtl/apbs_periph_sys.sv
// Module apbs_periph_sys: APB completer port split between a register
// peripheral and a switch peripheral. Peripherals decode only the low byte
// of the address. Error response is tied low.
module apbs_periph_sys
    import apbs_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_REGS = REGS_BASE,
    parameter logic [ADDR_W-1:0] BASE_SWCH = SWCH_BASE
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              led,
    input  logic              sw_a,
    input  logic              sw_b
);
    localparam logic [OFS_W-1:0] R_OFS = BASE_REGS[OFS_W-1:0];
    localparam logic [OFS_W-1:0] S_OFS = BASE_SWCH[OFS_W-1:0];

    logic [NUM_SLV-1:0]        sel_v;
    logic [NUM_SLV*DATA_W-1:0] rdata_v;
    logic [NUM_SLV-1:0]        ready_v;
    logic [OFS_W-1:0]          ofs;

    assign ofs     = paddr[OFS_W-1:0];
    assign pslverr = 1'b0;

    apbs_decode #(
        .ADDR_W(ADDR_W), .SPAN_LOG2(SPAN_LOG2), .NUM_SLV(NUM_SLV),
        .BASES({BASE_SWCH, BASE_REGS})
    ) u_decode (
        .psel(psel), .paddr_hi(paddr[ADDR_W-1:SPAN_LOG2]), .slv_sel(sel_v)
    );

    apbs_regdev #(
        .DATA_W(DATA_W), .OFS_W(OFS_W),
        .OFS_A(R_OFS), .OFS_B(R_OFS + 8'd4)
    ) u_regs (
        .pclk(pclk), .presetn(presetn), .sel(sel_v[SLOT_REGS]),
        .penable(penable), .pwrite(pwrite), .ofs(ofs), .pwdata(pwdata),
        .rdata(rdata_v[SLOT_REGS*DATA_W +: DATA_W]),
        .ready(ready_v[SLOT_REGS]), .led(led)
    );

    apbs_swdev #(
        .DATA_W(DATA_W), .OFS_W(OFS_W),
        .OFS_SA(S_OFS), .OFS_SB(S_OFS + 8'd4)
    ) u_swch (
        .sel(sel_v[SLOT_SWCH]), .ofs(ofs), .sw_a(sw_a), .sw_b(sw_b),
        .rdata(rdata_v[SLOT_SWCH*DATA_W +: DATA_W]),
        .ready(ready_v[SLOT_SWCH])
    );

    apbs_resp_mux #(.NUM_SLV(NUM_SLV), .DATA_W(DATA_W)) u_mux (
        .slv_sel(sel_v), .slv_rdata(rdata_v), .slv_ready(ready_v),
        .prdata(prdata), .pready(pready)
    );
endmodule

// File: rtl/apbs_periph_chk.sv
// Module apbs_periph_chk: port-level properties of apbs_periph_sys, bound
// to it below. Assumes the default address map.
module apbs_periph_chk (
    input logic        pclk,
    input logic        presetn,
    input logic        psel,
    input logic        penable,
    input logic        pwrite,
    input logic [31:0] paddr,
    input logic        wdata0,
    input logic [31:0] prdata,
    input logic        pready,
    input logic        pslverr,
    input logic        led,
    input logic        sw_a,
    input logic        sw_b
);
    p_reset_clears_r1: assert property (@(posedge pclk)
        !presetn |=> !led);

    p_led_follows_a_r4: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && pwrite && paddr == 32'h0000_1000)
        |=> (led == $past(wdata0)));

    p_no_write_r5: assert property (@(posedge pclk) disable iff (!presetn)
        !(psel && penable && pwrite) |=> $stable(led));

    p_sw_a_read_r7: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && paddr == 32'h0000_1010) |-> (prdata == {31'b0, sw_a}));

    p_sw_b_read_r7: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && paddr == 32'h0000_1014) |-> (prdata == {31'b0, sw_b}));

    p_unmapped_r8: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && paddr[31:5] != 27'h80) |-> (prdata == 32'h0 && pready));

    p_resp_fixed_r9: assert property (@(posedge pclk) disable iff (!presetn)
        pready && !pslverr);
endmodule

bind apbs_periph_sys apbs_periph_chk u_chk (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .wdata0(pwdata[0]), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .led(led), .sw_a(sw_a), .sw_b(sw_b)
);

// File: tb/test_apbs_periph_sys.sv
// Scoreboard bench: read tasks queue expected data, a monitor compares it in
// the access phase.
module test_apbs_periph_sys;
    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [31:0] paddr = '0, pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, led;
    logic        sw_a = 1'b0, sw_b = 1'b0;

    int checks = 0;
    int fails  = 0;

    typedef struct { logic [31:0] exp; string tag; } exp_t;
    exp_t sb_q[$];

    always #5 pclk = ~pclk;

    apbs_periph_sys i_apbs_periph_sys (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .led(led), .sw_a(sw_a), .sw_b(sw_b)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [31:0] a, input logic wr, input logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_write(input logic [31:0] a, input logic [31:0] d);
        xfer(a, 1'b1, d);
    endtask

    task automatic apb_read(input logic [31:0] a, input logic [31:0] exp, input string tag);
        exp_t e;
        e.exp = exp; e.tag = tag;
        sb_q.push_back(e);
        xfer(a, 1'b0, 32'h0);
    endtask

    // monitor: compare read data and response in the access phase
    always @(posedge pclk) begin
        #2;
        if (presetn && psel && penable && !pwrite) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "unexpected read", prdata, 32'h0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(prdata === e.exp, e.tag, prdata, e.exp);
                check(pready === 1'b1 && pslverr === 1'b0, "R9 response",
                      {30'b0, pready, pslverr}, 32'h2);
            end
        end
    end

    initial begin
        #1_000_000;
        check(1'b0, "watchdog", 32'h0, 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge pclk);
        check(led === 1'b0, "R1 led after reset", {31'b0, led}, 32'h0);
        presetn = 1'b1;
        apb_read(32'h1000, 32'h0, "R1 reg A reset");
        apb_read(32'h1004, 32'h0, "R1 reg B reset");

        apb_write(32'h1000, 32'hA5A5_0001);
        check(led === 1'b1, "R4 led set", {31'b0, led}, 32'h1);
        apb_read(32'h1000, 32'hA5A5_0001, "R2 reg A readback");
        apb_write(32'h1004, 32'h1234_5678);
        apb_read(32'h1004, 32'h1234_5678, "R3 reg B readback");
        apb_read(32'h1000, 32'hA5A5_0001, "R3 reg A untouched");
        apb_write(32'h1000, 32'hFFFF_FFFE);
        check(led === 1'b0, "R4 led cleared", {31'b0, led}, 32'h0);

        // R5: setup phase only, then psel low with penable and pwrite high
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b1; paddr = 32'h1000; pwdata = 32'h1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b1;
        @(negedge pclk);
        penable = 1'b0; pwrite = 1'b0;
        check(led === 1'b0, "R5 led unchanged", {31'b0, led}, 32'h0);
        apb_read(32'h1000, 32'hFFFF_FFFE, "R5 reg A unchanged");

        // R6: unused offsets and switch window writes
        apb_write(32'h1008, 32'h0000_0001);
        apb_write(32'h100C, 32'h0000_0001);
        apb_write(32'h1010, 32'h0000_0001);
        apb_read(32'h1008, 32'h0, "R6 offset 08 reads 0");
        apb_read(32'h100C, 32'h0, "R6 offset 0C reads 0");
        apb_read(32'h1000, 32'hFFFF_FFFE, "R6 reg A unchanged");
        apb_read(32'h1004, 32'h1234_5678, "R6 reg B unchanged");

        // R7: switch reads in two patterns
        sw_a = 1'b1; sw_b = 1'b0;
        apb_read(32'h1010, 32'h1, "R7 switch A high");
        apb_read(32'h1014, 32'h0, "R7 switch B low");
        sw_a = 1'b0; sw_b = 1'b1;
        apb_read(32'h1010, 32'h0, "R7 switch A low");
        apb_read(32'h1014, 32'h1, "R7 switch B high");
        apb_read(32'h1018, 32'h0, "R7 unused switch offset");

        // R8: unmapped addresses whose low byte matches register offsets
        apb_write(32'h2000, 32'h0000_0001);
        apb_write(32'h1100, 32'h0000_0001);
        apb_write(32'h2004, 32'h0);
        check(led === 1'b0, "R8 led unchanged", {31'b0, led}, 32'h0);
        apb_read(32'h2000, 32'h0, "R8 unmapped read 0");
        apb_read(32'h1020, 32'h0, "R8 past window reads 0");
        apb_read(32'h1000, 32'hFFFF_FFFE, "R8 reg A unchanged");
        apb_read(32'h1004, 32'h1234_5678, "R8 reg B unchanged");

        // R1: reset again after nonzero state
        @(negedge pclk); presetn = 1'b0;
        @(negedge pclk); presetn = 1'b1;
        apb_read(32'h1004, 32'h0, "R1 reg B cleared by reset");

        repeat (2) @(negedge pclk);
        check(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule